// File: doc/BRIEF.md
# Atomic Wake-Up Alarm Target Staging

This block holds the 47-bit target of a wake-up alarm. Software writes that target through three separate 16-bit registers: a low word, a high word and an extension word that carries 15 valid bits. A write to any of the three is held in a staging copy and marked pending. The live compare value does not change until all three have been written, in any order. The triple then loads as one step, so the comparator never sees a target made of old and new parts.

A flush input discards any partly written triple. A read of an alarm address returns the staged word while that word is pending, and the live word otherwise. The live target is compared every cycle with a free-running 47-bit count. When the alarm is enabled and the two are equal, a sticky alarm flag is set. Software clears that flag with a one-cycle clear strobe.

Top module: `alarm_stage`

## Requirements
- R1: After reset the live target is all ones (47'h7FFF_FFFF_FFFF), no word is pending, commit is low and the alarm flag is low.
- R2: Address map: 0 is the low word (target bits [30:15]), 1 is the high word (target bits [46:31]) and 2 is the extension (target bits [14:0]). A write sets the matching bit of `pending` (bit index = address) and leaves the live target unchanged until all three bits would be set.
- R3: The triple commits in whatever order the three words arrive. On the clock edge that takes the last missing word, the live target loads all three words, and `commit` is high for exactly the one cycle that follows.
- R4: Writing a word again before the triple completes replaces its staged value. The commit still waits for the other words.
- R5: On a commit all three pending bits clear in the same cycle that the target loads.
- R6: `flush` clears every pending bit and discards the staged triple. A write in the same cycle as a flush is dropped, and the live target is unchanged.
- R7: Bit 15 of a write to the extension address is ignored, and bit 15 of an extension read is always zero.
- R8: Writes are staged and committed whatever the level of `alm_en`.
- R9: When `alm_en` is high and `count` equals the live target at a clock edge, `alarm` is high from that edge on. When `alm_en` is low, no equality sets it.
- R10: A high `alm_clr` clears `alarm` at the next edge, unless the set condition of R9 holds on that same edge, in which case the set wins.
- R11: `rd_data` returns the staged word for a pending address and the live word otherwise. Address 3 reads zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| flush | input | 1 | Discard staged alarm writes |
| alm_en | input | 1 | Alarm compare enable |
| count | input | 47 | Free-running count |
| alm_clr | input | 1 | Clear strobe for the alarm flag |
| pending | output | 3 | Per-word pending flags |
| commit | output | 1 | One-cycle pulse after a triple loads |
| target | output | 47 | Live alarm target |
| alarm | output | 1 | Sticky alarm flag |

## Verification
The bench aims at a triple completed in every ordering, including orderings with repeated writes. A design that committed on a write count, and not on a full pending set, would load early after a rewrite. The bench drives a flush in the same cycle as the write that would complete a triple. A design that let the write win would commit a target that should have been dropped. It also checks reads while a word is pending, where a wrong mux returns the live value. Finally it drives a clear strobe on the same edge as an alarm match, which a design with the wrong priority would turn into a lost alarm.

// File: rtl/alarm_stage.sv
module alarm_stage #(
  parameter int WORD_W = 16,
  parameter int EXT_W  = 15,
  localparam int TGT_W = 2 * WORD_W + EXT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic              flush,
  input  logic              alm_en,
  input  logic [TGT_W-1:0]  count,
  input  logic              alm_clr,
  output logic [2:0]        pending,
  output logic              commit,
  output logic [TGT_W-1:0]  target,
  output logic              alarm
);
  localparam logic [WORD_W-1:0] WORD_ONES = '1;
  localparam logic [EXT_W-1:0]  EXT_ONES  = '1;

  logic [WORD_W-1:0] stg_lo, stg_hi, act_lo, act_hi;
  logic [EXT_W-1:0]  stg_ex, act_ex;
  logic [2:0]        sel, pend_nxt;
  logic              fire;

  always_comb begin
    sel = 3'b000;
    if (wr_en && wr_addr != 2'd3) sel[wr_addr] = 1'b1;
  end

  assign pend_nxt = pending | sel;
  assign fire     = !flush && (|sel) && (&pend_nxt);
  assign target   = {act_hi, act_lo, act_ex};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_lo  <= WORD_ONES;
      stg_hi  <= WORD_ONES;
      stg_ex  <= EXT_ONES;
      act_lo  <= WORD_ONES;
      act_hi  <= WORD_ONES;
      act_ex  <= EXT_ONES;
      pending <= 3'b000;
      commit  <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (flush) begin
        pending <= 3'b000;
      end else begin
        if (sel[0]) stg_lo <= wr_data;
        if (sel[1]) stg_hi <= wr_data;
        if (sel[2]) stg_ex <= wr_data[EXT_W-1:0];
        if (fire) begin
          act_lo  <= sel[0] ? wr_data : stg_lo;
          act_hi  <= sel[1] ? wr_data : stg_hi;
          act_ex  <= sel[2] ? wr_data[EXT_W-1:0] : stg_ex;
          pending <= 3'b000;
          commit  <= 1'b1;
        end else begin
          pending <= pend_nxt;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          alarm <= 1'b0;
    else if (alm_en && count == target)  alarm <= 1'b1;
    else if (alm_clr)                    alarm <= 1'b0;
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = pending[0] ? stg_lo : act_lo;
      2'd1:    rd_data = pending[1] ? stg_hi : act_hi;
      2'd2:    rd_data = WORD_W'(pending[2] ? stg_ex : act_ex);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/alarm_stage_chk.sv
module alarm_stage_chk #(
  parameter int WORD_W = 16,
  parameter int EXT_W  = 15,
  localparam int TGT_W = 2 * WORD_W + EXT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        rd_addr,
  input logic [WORD_W-1:0] rd_data,
  input logic              flush,
  input logic              alm_en,
  input logic [TGT_W-1:0]  count,
  input logic              alm_clr,
  input logic [2:0]        pending,
  input logic              commit,
  input logic [TGT_W-1:0]  target,
  input logic              alarm
);
  assert_commit_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> pending == 3'b000);

  assert_target_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |-> $stable(target));

  assert_flush_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (pending == 3'b000 && !commit));

  assert_ext_msb_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == 2'd2 |-> rd_data[WORD_W-1:EXT_W] == '0);

  assert_alarm_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_en && count == target) |=> alarm);

  assert_alarm_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !alm_clr) |=> alarm);
endmodule

bind alarm_stage alarm_stage_chk #(.WORD_W(WORD_W), .EXT_W(EXT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
  .flush(flush), .alm_en(alm_en), .count(count), .alm_clr(alm_clr),
  .pending(pending), .commit(commit), .target(target), .alarm(alarm)
);

// File: tb/alarm_stage_tb_top.sv
`timescale 1ns/1ps
module alarm_stage_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        flush = 1'b0;
  logic        alm_en = 1'b0;
  logic [46:0] count = '0;
  logic        alm_clr = 1'b0;
  logic [2:0]  pending;
  logic        commit;
  logic [46:0] target;
  logic        alarm;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [15:0] m_stg [3];
  logic [15:0] m_act [3];
  logic [2:0]  m_pend;
  logic        m_commit;
  logic        m_alarm;

  always #2.5 clk = ~clk;

  alarm_stage dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .flush(flush), .alm_en(alm_en),
    .count(count), .alm_clr(alm_clr), .pending(pending), .commit(commit),
    .target(target), .alarm(alarm)
  );

  function automatic logic [46:0] exp_target();
    return {m_act[1], m_act[0], m_act[2][14:0]};
  endfunction

  function automatic logic [15:0] exp_read(input logic [1:0] a);
    if (a == 2'd3) return 16'h0;
    return m_pend[a] ? m_stg[a] : m_act[a];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      m_stg[i] = 16'hFFFF;
      m_act[i] = (i == 2) ? 16'h7FFF : 16'hFFFF;
    end
    m_pend = 3'b000;
    m_commit = 1'b0;
    m_alarm = 1'b0;
  endtask

  task automatic check_all(input string req);
    check({req, " target"}, 64'(target), 64'(exp_target()));
    check({req, " pending"}, 64'(pending), 64'(m_pend));
    check({req, " commit"}, 64'(commit), 64'(m_commit));
    check({req, " alarm"}, 64'(alarm), 64'(m_alarm));
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #0.5;
      check({req, " R11 read"}, 64'(rd_data), 64'(exp_read(2'(a))));
    end
  endtask

  task automatic cycle(input bit fl, input bit we, input logic [1:0] a,
                       input logic [15:0] d, input bit en, input bit clr,
                       input logic [46:0] cnt);
    logic [2:0] sel;
    logic [2:0] nxt;
    @(negedge clk);
    flush = fl; wr_en = we; wr_addr = a; wr_data = d;
    alm_en = en; alm_clr = clr; count = cnt;
    @(posedge clk);
    if (en && cnt == exp_target()) m_alarm = 1'b1;
    else if (clr) m_alarm = 1'b0;
    sel = (we && a != 2'd3) ? (3'b001 << a) : 3'b000;
    m_commit = 1'b0;
    if (fl) m_pend = 3'b000;
    else begin
      for (int i = 0; i < 3; i++)
        if (sel[i]) m_stg[i] = (i == 2) ? {1'b0, d[14:0]} : d;
      nxt = m_pend | sel;
      if (sel != 0 && nxt == 3'b111) begin
        for (int i = 0; i < 3; i++) m_act[i] = m_stg[i];
        m_pend = 3'b000;
        m_commit = 1'b1;
      end else m_pend = nxt;
    end
    #1;
    flush = 0; wr_en = 0; alm_clr = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input string req);
    cycle(1'b0, 1'b1, a, d, 1'b0, 1'b0, 47'h0);
    check_all(req);
  endtask

  initial begin
    #300000;
    $display("FAIL watchdog expired actual=running expected=finished");
    n_chk++; n_bad++;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");
    check("R1 target ones", 64'(target), 64'h7FFF_FFFF_FFFF);

    wr(2'd1, 16'h1234, "R2 partial high");
    wr(2'd2, 16'hFFFF, "R7 ext msb");
    rd_addr = 2'd2; #0.5;
    check("R7 ext read msb", 64'(rd_data[15]), 64'h0);
    wr(2'd1, 16'h5678, "R4 rewrite");
    check("R4 still pending", 64'(pending), 64'b110);
    wr(2'd3, 16'hAAAA, "R11 addr3 ignored");
    wr(2'd0, 16'h9ABC, "R3 commit");
    check("R3 target value", 64'(target), 64'({16'h5678, 16'h9ABC, 15'h7FFF}));

    wr(2'd0, 16'h0001, "R6 prep");
    wr(2'd2, 16'h0002, "R6 prep");
    cycle(1'b1, 1'b1, 2'd1, 16'h0003, 1'b0, 1'b0, 47'h0);
    check_all("R6 flush beats write");
    check("R6 target kept", 64'(target), 64'({16'h5678, 16'h9ABC, 15'h7FFF}));

    cycle(1'b0, 1'b1, 2'd2, 16'h0011, 1'b1, 1'b0, 47'h1);
    check_all("R8 write with alm_en");
    cycle(1'b0, 1'b1, 2'd0, 16'h0022, 1'b1, 1'b0, 47'h1);
    check_all("R8 write with alm_en");
    cycle(1'b0, 1'b1, 2'd1, 16'h0033, 1'b1, 1'b0, 47'h1);
    check_all("R8 commit with alm_en");

    cycle(1'b0, 1'b0, 2'd0, 16'h0, 1'b0, 1'b0, exp_target());
    check_all("R9 disabled no set");
    check("R9 no alarm", 64'(alarm), 64'h0);
    cycle(1'b0, 1'b0, 2'd0, 16'h0, 1'b1, 1'b0, exp_target());
    check_all("R9 set");
    check("R9 alarm high", 64'(alarm), 64'h1);
    cycle(1'b0, 1'b0, 2'd0, 16'h0, 1'b0, 1'b0, 47'h0);
    check_all("R9 sticky");
    cycle(1'b0, 1'b0, 2'd0, 16'h0, 1'b1, 1'b1, exp_target());
    check_all("R10 set beats clear");
    check("R10 alarm kept", 64'(alarm), 64'h1);
    cycle(1'b0, 1'b0, 2'd0, 16'h0, 1'b0, 1'b1, 47'h0);
    check_all("R10 clear");
    check("R10 alarm cleared", 64'(alarm), 64'h0);

    for (int i = 0; i < 600; i++) begin
      int r = $urandom % 12;
      cycle(r == 0, r != 1, 2'($urandom % 4), 16'($urandom), 1'($urandom % 2),
            1'($urandom % 2), (r == 2) ? exp_target() : 47'h0);
      check_all("R3 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule